// File: doc/BRIEF.md
# Identification-Code Command Gate

This block sits between a byte-wide serial receiver and the unit that carries out flash commands. Before a programmer may operate on a non-empty flash, it must present a seven-byte identification code. The gate checks each code byte against a reference supplied at its input and opens only after all seven match in sequence. While the flash is reported empty, the gate is open without any code.

Once open, the gate passes read and status commands for any address. Program and erase commands are passed only when their target lies in the user region. Any write or erase aimed at the boot region is refused. A refused command is not passed on; the gate raises a single-cycle refusal pulse instead. Received bytes are tagged by the receiver as either identification bytes or command bytes, and each command byte arrives with its decoded target address.

Top module: `id_gate`

## Requirements
- R1: After reset, `cmd_valid` and `reject` are low and `unlocked` equals `flash_blank`.
- R2: Identification bytes are compared in order, byte k against `id_ref[8k+7:8k]`, starting at k=0. When the seventh byte (k=6) matches, `unlocked` goes high on the clock edge that takes that byte.
- R3: A single mismatching identification byte resets the comparison to byte 0. The gate stays locked until all seven bytes match in a row.
- R4: While locked and `flash_blank` is low, every command byte is refused: no `cmd_valid`, one `reject` pulse.
- R5: While `flash_blank` is high, the gate is open without any identification code.
- R6: Once unlocked, the gate stays unlocked until reset, whatever identification bytes follow.
- R7: Program (opcode 0x41) and erase (opcode 0x20) commands with `rx_addr >= BOOT_BASE` (default 0xF000) are refused even when the gate is open.
- R8: Program and erase commands with `rx_addr < BOOT_BASE` are forwarded when the gate is open. `cmd_byte`, `cmd_addr` and a one-cycle `cmd_valid` follow one clock after the input.
- R9: Every other opcode is forwarded when the gate is open, whatever its address.
- R10: Each command byte yields exactly one cycle of either `cmd_valid` or `reject`, never both.
- R11: Bytes tagged as identification bytes never produce `cmd_valid` or `reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_blank | input | 1 | High when the flash holds no data |
| id_ref | input | 56 | Reference code; byte k in bits 8k+7:8k |
| rx_byte | input | 8 | Received byte |
| rx_addr | input | 16 | Decoded target address of a command byte |
| rx_valid | input | 1 | Strobe: `rx_byte` is valid this cycle |
| rx_is_id | input | 1 | High: the byte belongs to the identification code |
| cmd_byte | output | 8 | Forwarded opcode |
| cmd_addr | output | 16 | Forwarded address |
| cmd_valid | output | 1 | One-cycle strobe for a forwarded command |
| reject | output | 1 | One-cycle strobe for a refused command |
| unlocked | output | 1 | Gate open |

## Verification
The bench builds the gate with its default parameters: a seven-byte code, 16-bit addresses and the boot region starting at 0xF000. With these values it can probe the addresses just below and exactly at the boundary, and a mismatch at the last code byte. It also checks that a partial match of six bytes leaves the gate shut, that the gate stays open when wrong code bytes arrive later, and that a blank flash opens the gate straight out of reset.

// File: rtl/id_gate.sv
module id_gate #(
  parameter int            ID_LEN    = 7,
  parameter int            AW        = 16,
  parameter logic [AW-1:0] BOOT_BASE = 16'hF000,
  parameter logic [7:0]    OP_PROG   = 8'h41,
  parameter logic [7:0]    OP_ERASE  = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flash_blank,
  input  logic [8*ID_LEN-1:0]   id_ref,
  input  logic [7:0]            rx_byte,
  input  logic [AW-1:0]         rx_addr,
  input  logic                  rx_valid,
  input  logic                  rx_is_id,
  output logic [7:0]            cmd_byte,
  output logic [AW-1:0]         cmd_addr,
  output logic                  cmd_valid,
  output logic                  reject,
  output logic                  unlocked
);
  localparam int IW = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(ID_LEN - 1);

  logic [IW-1:0] pos;
  logic          unl_q;

  wire open_w  = unl_q | flash_blank;
  wire is_cmd  = rx_valid & ~rx_is_id;
  wire is_id   = rx_valid & rx_is_id;
  wire id_hit  = rx_byte == id_ref[pos*8 +: 8];
  wire is_mod  = (rx_byte == OP_PROG) || (rx_byte == OP_ERASE);
  wire in_boot = rx_addr >= BOOT_BASE;
  wire pass    = open_w & ~(is_mod & in_boot);

  assign unlocked = open_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      unl_q     <= 1'b0;
      cmd_valid <= 1'b0;
      reject    <= 1'b0;
      cmd_byte  <= '0;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= is_cmd & pass;
      reject    <= is_cmd & ~pass;
      if (is_cmd) begin
        cmd_byte <= rx_byte;
        cmd_addr <= rx_addr;
      end
      if (is_id && !unl_q) begin
        if (!id_hit)          pos <= '0;
        else if (pos == LAST) begin
          pos   <= '0;
          unl_q <= 1'b1;
        end else              pos <= pos + 1'b1;
      end
    end
  end

  a_r4_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && !unl_q && !flash_blank |=> reject && !cmd_valid);

  a_r7_boot_refused: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && is_mod && in_boot |=> reject && !cmd_valid);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |=> unl_q);

  a_r2_unlock_on_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(is_id && rx_byte == id_ref[8*ID_LEN-1 -: 8]));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && reject));

  a_r11_id_silent: assert property (@(posedge clk) disable iff (!rst_n)
    is_id |=> !cmd_valid && !reject);
endmodule

// File: tb/id_gate_bench.sv
`timescale 1ns/1ps
module id_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flash_blank = 1'b0;
  logic [55:0] id_ref = 56'hA1_B2_C3_D4_E5_F6_07;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rx_addr = '0;
  logic        rx_valid = 1'b0;
  logic        rx_is_id = 1'b0;
  logic [7:0]  cmd_byte;
  logic [15:0] cmd_addr;
  logic        cmd_valid, reject, unlocked;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  id_gate u_id_gate (.*);

  localparam logic [24:0] VEC [8] = '{
    {8'h41, 16'h1000, 1'b1},
    {8'h20, 16'hEFFF, 1'b1},
    {8'h41, 16'hF000, 1'b0},
    {8'h20, 16'hFFFF, 1'b0},
    {8'h05, 16'hF800, 1'b1},
    {8'h70, 16'hF000, 1'b1},
    {8'hFF, 16'h0000, 1'b1},
    {8'h20, 16'hF000, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic id, logic [15:0] a);
    @(negedge clk);
    rx_byte = b; rx_is_id = id; rx_addr = a; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset(logic blank);
    @(negedge clk);
    rst_n = 1'b0; flash_blank = blank;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cmd_expect(string req, logic [7:0] op, logic [15:0] a, logic fwd);
    send(op, 1'b0, a);
    check(req, {30'd0, cmd_valid, reject}, {30'd0, fwd, !fwd});
    if (fwd) check(req, {8'd0, cmd_byte, cmd_addr}, {8'd0, op, a});
    @(negedge clk);
    check({req, " single pulse R10"}, {30'd0, cmd_valid, reject}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R1 reset", {29'd0, cmd_valid, reject, unlocked}, 32'd0);

    cmd_expect("R4 locked read", 8'h05, 16'h0100, 1'b0);

    for (int i = 0; i < 6; i++) begin
      send(id_ref[i*8 +: 8], 1'b1, '0);
      check("R11 id byte silent", {30'd0, cmd_valid, reject}, 32'd0);
    end
    check("R2 six bytes not enough", {31'd0, unlocked}, 32'd0);
    send(8'h00, 1'b1, '0);
    check("R3 mismatch at last byte", {31'd0, unlocked}, 32'd0);
    send(id_ref[55:48], 1'b1, '0);
    check("R3 progress cleared", {31'd0, unlocked}, 32'd0);
    for (int i = 0; i < 7; i++) send(id_ref[i*8 +: 8], 1'b1, '0);
    check("R2 full match unlocks", {31'd0, unlocked}, 32'd1);

    foreach (VEC[k])
      cmd_expect(VEC[k][24:17] == 8'h41 || VEC[k][24:17] == 8'h20 ?
                 (VEC[k][0] ? "R8 user modify" : "R7 boot modify") : "R9 other op",
                 VEC[k][24:17], VEC[k][16:1], VEC[k][0]);

    for (int i = 0; i < 3; i++) send(8'h99, 1'b1, '0);
    check("R6 stays unlocked", {31'd0, unlocked}, 32'd1);
    cmd_expect("R6 forwards after bad id", 8'h05, 16'h0000, 1'b1);

    do_reset(1'b0);
    @(negedge clk);
    check("R1 reset relocks", {31'd0, unlocked}, 32'd0);

    do_reset(1'b1);
    @(negedge clk);
    check("R1 reset blank", {31'd0, unlocked}, 32'd1);
    cmd_expect("R5 blank open", 8'h41, 16'h0200, 1'b1);
    cmd_expect("R5 blank still guards boot R7", 8'h41, 16'hF000, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule